// File: doc/BRIEF.md
# Read-Locked ADC Result Register

This block holds the latest 10-bit result from a successive-approximation converter and shows it on a byte-wide read path as a low byte and a high byte. Software reads the low byte first and then the high byte. The block guarantees that such a pair of reads returns two halves of the same conversion. The first read freezes the stored result. The second read releases it.

While the result is frozen, the block drops any conversion that finishes, but it still reports that the conversion completed. An alignment control sets the layout. With right alignment the result sits in the low bits. With left alignment the top eight bits of the result fill the high byte, so a reader that needs only 8-bit precision can read just the high byte. A read of the high byte never sets the freeze.

Top module: `adc_result_latch`

## Requirements
- R1: After reset both bytes read 0x00, `locked_o` is low and `done_o` is low.
- R2: With `left_adj_i` = 0, `lo_byte_o` is result bits 7:0 and `hi_byte_o` is {6'b0, result bits 9:8}.
- R3: With `left_adj_i` = 1, `hi_byte_o` is result bits 9:2 and `lo_byte_o` is {result bits 1:0, 6'b0}.
- R4: A change of `left_adj_i` re-presents the stored result in the same cycle, with no new conversion.
- R5: When `res_valid_i` is high, no lock is held and there is no low-byte read, `res_data_i` is stored and appears on the bytes after the next clock edge.
- R6: A one-cycle `rd_lo_i` pulse raises `locked_o` after that clock edge.
- R7: While the lock is held, a result on `res_valid_i` changes neither byte. That result is lost and is still missing after the lock is released.
- R8: A `rd_hi_i` pulse clears `locked_o` after that clock edge. The next result is stored again as in R5.
- R9: `done_o` is high for exactly the one cycle after each cycle with `res_valid_i` high. This includes results that were discarded.
- R10: A `rd_hi_i` pulse while no lock is held leaves `locked_o` low and both bytes unchanged.
- R11: A result that arrives in the same cycle as `rd_lo_i` is dropped. The low byte read in that cycle shows the previously stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Converter result strobe |
| res_data_i | input | 10 | Converter result |
| left_adj_i | input | 1 | 1 = left-aligned presentation |
| rd_lo_i | input | 1 | Low-byte read strobe |
| rd_hi_i | input | 1 | High-byte read strobe |
| lo_byte_o | output | 8 | Low byte of the stored result |
| hi_byte_o | output | 8 | High byte of the stored result |
| locked_o | output | 1 | Stored result is frozen |
| done_o | output | 1 | Conversion-complete pulse |

## Verification
The assertions check on every cycle that the stored word holds still under a lock or a low-byte read, that an accepted result is stored exactly, that each read strobe moves the lock as expected, and that every result strobe produces a completion pulse. Only the bench scenarios can show end-to-end behaviour. These include the byte layouts for both alignments across varied data, a re-presentation when alignment changes, a result that is lost and stays lost after release, and a result that collides with a low-byte read.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  parameter int unsigned RES_W  = 10;
  parameter int unsigned BYTE_W = 8;
endpackage

// File: rtl/adc_res_lock.sv
module adc_res_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_lo_i,
  input  logic rd_hi_i,
  output logic locked_o,
  output logic accept_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      locked_q <= 1'b0;
    else if (rd_lo_i) locked_q <= 1'b1;
    else if (rd_hi_i) locked_q <= 1'b0;
  end

  // a low-byte read wins over a result arriving in the same cycle
  assign accept_o = !locked_q && !rd_lo_i;
  assign locked_o = locked_q;

  // R6
  lock_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> locked_o);
  // R8
  lock_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi_i && !rd_lo_i) |=> !locked_o);
  // R10
  lock_hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_o && !rd_lo_i) |=> !locked_o);
endmodule

// File: rtl/adc_res_store.sv
module adc_res_store #(
  parameter int unsigned RES_W = adc_res_pkg::RES_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             res_valid_i,
  input  logic             accept_i,
  input  logic [RES_W-1:0] res_data_i,
  output logic [RES_W-1:0] res_o,
  output logic             done_o
);
  logic [RES_W-1:0] res_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= res_valid_i;  // reported even when the data is dropped
      if (res_valid_i && accept_i) res_q <= res_data_i;
    end
  end

  assign res_o  = res_q;
  assign done_o = done_q;

  // R7
  frozen_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(res_o));
  // R5
  accept_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && accept_i) |=> (res_o == $past(res_data_i)));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> done_o);
  // R9
  done_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> !done_o);
endmodule

// File: rtl/adc_res_format.sv
module adc_res_format #(
  parameter int unsigned RES_W  = adc_res_pkg::RES_W,
  parameter int unsigned BYTE_W = adc_res_pkg::BYTE_W
) (
  input  logic [RES_W-1:0]  res_i,
  input  logic              left_adj_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o
);
  localparam int unsigned WORD_W = 2 * BYTE_W;
  localparam int unsigned PAD_W  = WORD_W - RES_W;

  logic [WORD_W-1:0] right_w, left_w, word;

  generate
    if (PAD_W == 0) begin : g_full
      assign right_w = res_i;
      assign left_w  = res_i;
    end else begin : g_pad
      assign right_w = {{PAD_W{1'b0}}, res_i};
      assign left_w  = {res_i, {PAD_W{1'b0}}};
    end
  endgenerate

  assign word = left_adj_i ? left_w : right_w;
  assign lo_o = word[BYTE_W-1:0];
  assign hi_o = word[WORD_W-1:BYTE_W];
endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch #(
  parameter int unsigned RES_W  = adc_res_pkg::RES_W,
  parameter int unsigned BYTE_W = adc_res_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_valid_i,
  input  logic [RES_W-1:0]  res_data_i,
  input  logic              left_adj_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  output logic [BYTE_W-1:0] lo_byte_o,
  output logic [BYTE_W-1:0] hi_byte_o,
  output logic              locked_o,
  output logic              done_o
);
  logic             accept;
  logic [RES_W-1:0] res;

  adc_res_lock u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_lo_i  (rd_lo_i),
    .rd_hi_i  (rd_hi_i),
    .locked_o (locked_o),
    .accept_o (accept)
  );

  adc_res_store #(.RES_W(RES_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .res_valid_i (res_valid_i),
    .accept_i    (accept),
    .res_data_i  (res_data_i),
    .res_o       (res),
    .done_o      (done_o)
  );

  adc_res_format #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
    .res_i      (res),
    .left_adj_i (left_adj_i),
    .lo_o       (lo_byte_o),
    .hi_o       (hi_byte_o)
  );

  // R11
  coincident_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lo_i && $stable(left_adj_i)) |=> ($stable(lo_byte_o) && $stable(hi_byte_o)));
endmodule

// File: tb/adc_result_latch_bench.sv
module adc_result_latch_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [9:0] data = '0;
  logic       left = 1'b0;
  logic       rd_lo = 1'b0;
  logic       rd_hi = 1'b0;
  logic [7:0] lo_b, hi_b;
  logic       locked, done;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         ended = 1'b0;

  always #4 clk = ~clk;

  adc_result_latch u_adc_result_latch (
    .clk_i (clk), .rst_ni (rst_n), .res_valid_i (valid), .res_data_i (data),
    .left_adj_i (left), .rd_lo_i (rd_lo), .rd_hi_i (rd_hi),
    .lo_byte_o (lo_b), .hi_byte_o (hi_b), .locked_o (locked), .done_o (done)
  );

  // {data, left, expected lo, expected hi}
  localparam logic [26:0] VEC [8] = '{
    {10'h3FF, 1'b0, 8'hFF, 8'h03},
    {10'h3FF, 1'b1, 8'hC0, 8'hFF},
    {10'h2A5, 1'b0, 8'hA5, 8'h02},
    {10'h2A5, 1'b1, 8'h40, 8'hA9},
    {10'h155, 1'b0, 8'h55, 8'h01},
    {10'h155, 1'b1, 8'h40, 8'h55},
    {10'h000, 1'b1, 8'h00, 8'h00},
    {10'h203, 1'b1, 8'hC0, 8'h80}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    #3;
    // R1 reset
    chk("R1 lo", lo_b, 8'h00); chk("R1 hi", hi_b, 8'h00);
    chk("R1 lock", locked, 1'b0); chk("R1 done", done, 1'b0);
    #10 rst_n = 1'b1;
    step();

    // R2 R3 R5 R9 vector walk
    for (int i = 0; i < 8; i++) begin
      data = VEC[i][26:17]; left = VEC[i][16]; valid = 1'b1;
      step();
      valid = 1'b0;
      chk("R2/R3 lo", lo_b, VEC[i][15:8]);
      chk("R2/R3 hi", hi_b, VEC[i][7:0]);
      chk("R9 done", done, 1'b1);
      step();
      chk("R9 done drop", done, 1'b0);
    end

    // R4 stored 0x203, flip alignment only
    left = 1'b0; #1;
    chk("R4 lo", lo_b, 8'h03); chk("R4 hi", hi_b, 8'h02);
    left = 1'b1; #1;
    chk("R4 hi left", hi_b, 8'h80);
    left = 1'b0;
    step();

    // R6 R7 R9 lock, discard, still flagged
    rd_lo = 1'b1; step(); rd_lo = 1'b0;
    chk("R6 lock", locked, 1'b1);
    data = 10'h1C7; valid = 1'b1; step(); valid = 1'b0;
    chk("R7 lo", lo_b, 8'h03); chk("R7 hi", hi_b, 8'h02);
    chk("R9 done discard", done, 1'b1);
    chk("R7 lock", locked, 1'b1);
    rd_hi = 1'b1; step(); rd_hi = 1'b0;
    chk("R8 unlock", locked, 1'b0);
    chk("R7 lost lo", lo_b, 8'h03);
    data = 10'h1C7; valid = 1'b1; step(); valid = 1'b0;
    chk("R8 lo", lo_b, 8'hC7); chk("R8 hi", hi_b, 8'h01);

    // R10 high read without lock
    rd_hi = 1'b1; step(); rd_hi = 1'b0;
    chk("R10 lock", locked, 1'b0);
    chk("R10 lo", lo_b, 8'hC7); chk("R10 hi", hi_b, 8'h01);

    // R11 coincident result and low read
    @(posedge clk); #2;
    rd_lo = 1'b1; data = 10'h07E; valid = 1'b1; #1;
    chk("R11 read old", lo_b, 8'hC7);
    step(); rd_lo = 1'b0; valid = 1'b0;
    chk("R11 lo", lo_b, 8'hC7); chk("R11 hi", hi_b, 8'h01);
    chk("R11 lock", locked, 1'b1);
    rd_hi = 1'b1; step(); rd_hi = 1'b0;
    chk("R11 release", locked, 1'b0);
    chk("R11 still old", lo_b, 8'hC7);

    step();
    finish_run();
  end
endmodule